// File: doc/BRIEF.md
# Power-Register Command Engine

This block sits on the controller side of a host-to-controller mailbox and carries out power-controller register commands. When the mailbox presents a command, the engine takes a snapshot of the 16-byte write-buffer image. It splits the image into fixed-stride records and runs one byte-wide access per record on a simple register port with a 16-bit address. Accesses run in ascending record order.

Three sub-commands exist: plain write, plain read, and masked update. A masked update reads the register and then writes it back with only the selected bits replaced. Read results are packed into a 16-byte result buffer, and the engine then pulses done. Commands that cannot be decoded end at once with an error code and never touch the register port. Messages with any other code are ignored.

The register file behind the port and the mailbox storage are outside this block. The register port returns read data combinationally in the same cycle as the read strobe.

Top module: `pwr_cmd_engine`

## Requirements
- R1: A command is accepted only when `start` is high, `msg_code` equals 0xFF and the engine is idle (`busy` low). Any other message code, and any `start` while `busy` is high, is ignored: no done pulse, no register access, and `busy` stays as it was.
- R2: Sub-command 0 (write) uses 3-byte records. Record k holds the address low byte at buffer byte 3k, the address high byte at 3k+1 and the data byte at 3k+2. The data byte is written to that address.
- R3: Sub-command 1 (read) uses 3-byte records with the address at bytes 3k and 3k+1. The value read for record k lands in result byte 3k+2. Every other result byte is zero, because the result buffer is cleared on each accepted command.
- R4: Sub-command 2 (masked update) uses 4-byte records: address low at 4k, address high at 4k+1, new bits at 4k+2 and mask at 4k+3. Each record makes one read cycle, then one write cycle to the same address, and writes (old AND NOT mask) OR (new AND mask).
- R5: Records run in ascending order with one port access per cycle. A read strobe and a write strobe are never high in the same cycle.
- R6: If `size` is not a whole multiple of the record stride, implies more than five records, or exceeds 16 bytes, the command ends with error code 0x02 and makes no register access.
- R7: A sub-command id other than 0, 1 or 2 ends the command with error code 0x01 and makes no register access. This check takes priority over the size check.
- R8: `done` is a one-cycle pulse that comes N+1 cycles after the accepting clock edge, where N is the number of port accesses. `err` is high only together with `done`, exactly when the error code is nonzero. `busy` is high from the accepting edge through the done cycle. `err_code` (0x00 when there is no error) holds its value until the next accepted command.
- R9: A valid sub-command with `size` 0 finishes one cycle after acceptance with error code 0x00 and makes no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command present from the mailbox |
| msg_code | input | 8 | Message code; only 0xFF is acted on |
| sub_id | input | 4 | Sub-command: 0 write, 1 read, 2 masked update |
| size | input | 8 | Payload bytes used by the records |
| wbuf | input | 128 | Write-buffer image, byte i at bits 8i+7:8i |
| busy | output | 1 | Command in progress |
| reg_addr | output | 16 | Register port address |
| reg_rd_en | output | 1 | Register read strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid with the read strobe |
| rbuf | output | 128 | Result buffer, byte i at bits 8i+7:8i |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done |
| err_code | output | 8 | Completion code, held until the next command |

## Verification
The bench builds the engine with its default parameters: five records at most and a 16-byte buffer. With these values, the five-record write and read lists both fit the buffer. A five-record masked update (20 bytes) runs past the buffer, so it is an error case, while four masked updates fill the buffer exactly. These values also put the highest read slot at byte 14 and the last mask byte at byte 15. The bench keeps its own register image and its own record decoder, and compares against them the register contents, the result buffer, the order and kind of every port access, and the completion latency.

// File: rtl/pwr_cmd_pkg.sv
package pwr_cmd_pkg;

  localparam logic [7:0] MSG_PWR = 8'hFF;

  localparam logic [3:0] SUB_WR  = 4'd0;
  localparam logic [3:0] SUB_RD  = 4'd1;
  localparam logic [3:0] SUB_RMW = 4'd2;

  localparam logic [7:0] CODE_OK   = 8'h00;
  localparam logic [7:0] CODE_SUB  = 8'h01;
  localparam logic [7:0] CODE_SIZE = 8'h02;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_RMW_WR,
    ST_DONE
  } eng_state_t;

  // Bytes per record for a sub-command; 0 marks an unknown id.
  function automatic int rec_stride(input logic [3:0] sub);
    case (sub)
      SUB_WR, SUB_RD: rec_stride = 3;
      SUB_RMW:        rec_stride = 4;
      default:        rec_stride = 0;
    endcase
  endfunction

  // Bits set in the mask take the new value; the others keep the old one.
  function automatic logic [7:0] mask_merge(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic [7:0] mask);
    mask_merge = (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
  import pwr_cmd_pkg::*;
#(
  parameter int MAX_REC   = 5,
  parameter int BUF_BYTES = 16,
  localparam int CNT_W    = $clog2(MAX_REC + 1)
) (
  input  logic [3:0]       sub_id,
  input  logic [7:0]       size,
  output logic             sub_ok,
  output logic             size_ok,
  output logic [CNT_W-1:0] rec_count
);

  int  stride;
  logic hit;

  always_comb begin
    stride    = rec_stride(sub_id);
    sub_ok    = (stride != 0);
    hit       = 1'b0;
    rec_count = '0;
    for (int r = 0; r <= MAX_REC; r++) begin
      if (sub_ok && (r * stride == int'(size))) begin
        hit       = 1'b1;
        rec_count = CNT_W'(r);
      end
    end
    size_ok = hit && (int'(size) <= BUF_BYTES);
  end

endmodule

// File: rtl/pwr_rec_fetch.sv
module pwr_rec_fetch
  import pwr_cmd_pkg::*;
#(
  parameter int MAX_REC   = 5,
  parameter int BUF_BYTES = 16,
  localparam int CNT_W    = $clog2(MAX_REC + 1),
  localparam int BUF_W    = 8 * BUF_BYTES
) (
  input  logic [BUF_W-1:0] buf_img,
  input  logic [3:0]       sub_id,
  input  logic [CNT_W-1:0] idx,
  output logic [15:0]      rec_addr,
  output logic [7:0]       rec_data,
  output logic [7:0]       rec_mask
);

  function automatic logic [7:0] byte_at(input logic [BUF_W-1:0] b, input int p);
    if (p >= 0 && p < BUF_BYTES) byte_at = b[8*p +: 8];
    else                         byte_at = 8'h00;
  endfunction

  int base;

  always_comb begin
    base     = int'(idx) * rec_stride(sub_id);
    rec_addr = {byte_at(buf_img, base + 1), byte_at(buf_img, base)};
    rec_data = byte_at(buf_img, base + 2);
    rec_mask = byte_at(buf_img, base + 3);
  end

endmodule

// File: rtl/pwr_rbuf_pack.sv
module pwr_rbuf_pack #(
  parameter int BUF_BYTES = 16,
  parameter int SLOT_W    = 5,
  localparam int BUF_W    = 8 * BUF_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [SLOT_W-1:0] slot,
  input  logic [7:0]        din,
  output logic [BUF_W-1:0]  rbuf
);

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                               rbuf[8*g +: 8] <= 8'h00;
      else if (clr)                             rbuf[8*g +: 8] <= 8'h00;
      else if (we && (int'(slot) == g))         rbuf[8*g +: 8] <= din;
    end
  end

endmodule

// File: rtl/pwr_cmd_engine.sv
module pwr_cmd_engine
  import pwr_cmd_pkg::*;
#(
  parameter int MAX_REC   = 5,
  parameter int BUF_BYTES = 16,
  localparam int CNT_W    = $clog2(MAX_REC + 1),
  localparam int BUF_W    = 8 * BUF_BYTES,
  localparam int SLOT_W   = $clog2(3 * MAX_REC + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       msg_code,
  input  logic [3:0]       sub_id,
  input  logic [7:0]       size,
  input  logic [BUF_W-1:0] wbuf,
  output logic             busy,
  output logic [15:0]      reg_addr,
  output logic             reg_rd_en,
  output logic             reg_wr_en,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata,
  output logic [BUF_W-1:0] rbuf,
  output logic             done,
  output logic             err,
  output logic [7:0]       err_code
);

  eng_state_t       state;
  logic [BUF_W-1:0] buf_q;
  logic [3:0]       sub_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic [7:0]       old_q;
  logic [7:0]       code_q;

  // Named internal events for the checker.
  logic             accept;
  logic             sub_ok;
  logic             size_ok;
  logic [CNT_W-1:0] dec_count;
  logic             rec_last;
  logic             step_end;

  logic [15:0]      rec_addr;
  logic [7:0]       rec_data;
  logic [7:0]       rec_mask;

  pwr_cmd_decode #(.MAX_REC(MAX_REC), .BUF_BYTES(BUF_BYTES)) u_decode (
    .sub_id    (sub_id),
    .size      (size),
    .sub_ok    (sub_ok),
    .size_ok   (size_ok),
    .rec_count (dec_count)
  );

  pwr_rec_fetch #(.MAX_REC(MAX_REC), .BUF_BYTES(BUF_BYTES)) u_fetch (
    .buf_img  (buf_q),
    .sub_id   (sub_q),
    .idx      (idx),
    .rec_addr (rec_addr),
    .rec_data (rec_data),
    .rec_mask (rec_mask)
  );

  assign accept   = (state == ST_IDLE) && start && (msg_code == MSG_PWR);
  assign rec_last = (idx == cnt_q - CNT_W'(1));
  assign step_end = ((state == ST_RUN) && (sub_q != SUB_RMW)) || (state == ST_RMW_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      buf_q  <= '0;
      sub_q  <= SUB_WR;
      cnt_q  <= '0;
      idx    <= '0;
      old_q  <= 8'h00;
      code_q <= CODE_OK;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            buf_q <= wbuf;
            sub_q <= sub_id;
            cnt_q <= dec_count;
            idx   <= '0;
            if (!sub_ok) begin
              code_q <= CODE_SUB;
              state  <= ST_DONE;
            end else if (!size_ok) begin
              code_q <= CODE_SIZE;
              state  <= ST_DONE;
            end else begin
              code_q <= CODE_OK;
              state  <= (dec_count == '0) ? ST_DONE : ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (sub_q == SUB_RMW) begin
            old_q <= reg_rdata;
            state <= ST_RMW_WR;
          end else if (rec_last) begin
            state <= ST_DONE;
          end else begin
            idx <= idx + CNT_W'(1);
          end
        end
        ST_RMW_WR: begin
          if (rec_last) begin
            state <= ST_DONE;
          end else begin
            idx   <= idx + CNT_W'(1);
            state <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign reg_addr  = busy ? rec_addr : 16'h0000;
  assign reg_rd_en = (state == ST_RUN) && (sub_q != SUB_WR);
  assign reg_wr_en = ((state == ST_RUN) && (sub_q == SUB_WR)) || (state == ST_RMW_WR);
  assign reg_wdata = (state == ST_RMW_WR) ? mask_merge(old_q, rec_data, rec_mask)
                                          : (reg_wr_en ? rec_data : 8'h00);
  assign done      = (state == ST_DONE);
  assign err       = done && (code_q != CODE_OK);
  assign err_code  = code_q;

  logic [SLOT_W-1:0] slot;
  assign slot = SLOT_W'(3 * int'(idx) + 2);

  pwr_rbuf_pack #(.BUF_BYTES(BUF_BYTES), .SLOT_W(SLOT_W)) u_rbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .we    ((state == ST_RUN) && (sub_q == SUB_RD)),
    .slot  (slot),
    .din   (reg_rdata),
    .rbuf  (rbuf)
  );

endmodule

// File: rtl/pwr_cmd_chk.sv
module pwr_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [7:0]  msg_code,
  input logic        busy,
  input logic [15:0] reg_addr,
  input logic        reg_rd_en,
  input logic        reg_wr_en,
  input logic        done,
  input logic        err,
  input logic [7:0]  err_code,
  input logic        accept,
  input logic        sub_ok,
  input logic        size_ok,
  input logic [3:0]  sub_q
);

  assert_foreign_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && msg_code != 8'hFF && !busy) |=> !busy);

  assert_rmw_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && sub_q == 4'd2) |-> ($past(reg_rd_en) && $stable(reg_addr)));

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_en && reg_wr_en));

  assert_size_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sub_ok && !size_ok) |=> (done && err && err_code == 8'h02 && !reg_rd_en && !reg_wr_en));

  assert_sub_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sub_ok) |=> (done && err && err_code == 8'h01 && !reg_rd_en && !reg_wr_en));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_busy_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

endmodule

bind pwr_cmd_engine pwr_cmd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .msg_code  (msg_code),
  .busy      (busy),
  .reg_addr  (reg_addr),
  .reg_rd_en (reg_rd_en),
  .reg_wr_en (reg_wr_en),
  .done      (done),
  .err       (err),
  .err_code  (err_code),
  .accept    (accept),
  .sub_ok    (sub_ok),
  .size_ok   (size_ok),
  .sub_q     (sub_q)
);

// File: tb/pwr_cmd_engine_tb.sv
module pwr_cmd_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic [3:0] sub;
    logic [7:0] size;
    logic [7:0] seed;
    logic [7:0] code;
    logic [7:0] lat;
  } vec_t;

  // sub, size, seed, expected code, expected cycles to done
  localparam vec_t VECS [NV] = '{
    '{4'd1, 8'd6,  8'd1, 8'h00, 8'd3},  // R3 two reads
    '{4'd0, 8'd3,  8'd2, 8'h00, 8'd2},  // R2 one write, R3 result cleared
    '{4'd0, 8'd15, 8'd3, 8'h00, 8'd6},  // R2 five writes
    '{4'd2, 8'd4,  8'd4, 8'h00, 8'd3},  // R4 one masked update
    '{4'd2, 8'd16, 8'd5, 8'h00, 8'd9},  // R4 four masked updates
    '{4'd1, 8'd15, 8'd6, 8'h00, 8'd6},  // R3 five reads
    '{4'd0, 8'd4,  8'd7, 8'h02, 8'd1},  // R6 not a multiple
    '{4'd0, 8'd18, 8'd8, 8'h02, 8'd1},  // R6 six records
    '{4'd2, 8'd20, 8'd9, 8'h02, 8'd1},  // R6 over buffer
    '{4'd2, 8'd6,  8'd10, 8'h02, 8'd1}, // R6 not a multiple
    '{4'd3, 8'd3,  8'd11, 8'h01, 8'd1}, // R7
    '{4'd15, 8'd0, 8'd12, 8'h01, 8'd1}, // R7 priority over size
    '{4'd1, 8'd0,  8'd13, 8'h00, 8'd1}  // R9
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [7:0]   msg_code = 8'h00;
  logic [3:0]   sub_id = 4'd0;
  logic [7:0]   size = 8'd0;
  logic [127:0] wbuf = '0;
  logic         busy;
  logic [15:0]  reg_addr;
  logic         reg_rd_en;
  logic         reg_wr_en;
  logic [7:0]   reg_wdata;
  logic [7:0]   reg_rdata;
  logic [127:0] rbuf;
  logic         done;
  logic         err;
  logic [7:0]   err_code;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_code(msg_code),
    .sub_id(sub_id), .size(size), .wbuf(wbuf), .busy(busy),
    .reg_addr(reg_addr), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rbuf(rbuf),
    .done(done), .err(err), .err_code(err_code)
  );

  // Register file model and access log.
  logic [7:0]  regs [256];
  logic [15:0] log_addr [512];
  logic        log_wr [512];
  int          log_n = 0;

  assign reg_rdata = regs[reg_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regs[i] <= 8'(i * 7 + 3);
    end else begin
      if (reg_wr_en) regs[reg_addr[7:0]] <= reg_wdata;
      if ((reg_rd_en || reg_wr_en) && log_n < 512) begin
        log_addr[log_n] <= reg_addr;
        log_wr[log_n]   <= reg_wr_en;
        log_n           <= log_n + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] make_buf(input logic [7:0] seed);
    logic [127:0] b;
    for (int i = 0; i < 16; i++) b[8*i +: 8] = 8'(int'(seed) * 37 + i * 29 + 11);
    return b;
  endfunction

  // Issue a command and wait for done; returns cycles from accept to done.
  int           got_lat;
  logic [7:0]   got_code;
  logic         got_err;
  logic [127:0] got_rbuf;

  task automatic run_cmd(input logic [3:0] s, input logic [7:0] sz, input logic [127:0] b);
    @(negedge clk);
    start = 1'b1; msg_code = 8'hFF; sub_id = s; size = sz; wbuf = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    got_lat = 1;
    while (!done && got_lat < 40) begin
      @(negedge clk);
      got_lat++;
    end
    got_code = err_code;
    got_err  = err;
    got_rbuf = rbuf;
    @(negedge clk);
  endtask

  logic [7:0]   exp_regs [256];
  logic [127:0] exp_rbuf;
  logic [15:0]  exp_addr [64];
  logic         exp_wr [64];
  int           exp_n;

  // Requirement model: decodes records independently of the design.
  task automatic model(input logic [3:0] s, input logic [7:0] sz,
                       input logic [127:0] b, input logic [7:0] code);
    int stride;
    logic [15:0] a;
    logic [7:0] nv, mk, ov;
    exp_rbuf = '0;
    exp_n = 0;
    stride = (s == 4'd2) ? 4 : 3;
    if (code != 8'h00) return;
    for (int r = 0; r < int'(sz) / stride; r++) begin
      a = {b[8*(r*stride+1) +: 8], b[8*(r*stride) +: 8]};
      nv = b[8*(r*stride+2) +: 8];
      case (s)
        4'd0: begin
          exp_regs[a[7:0]] = nv;
          exp_addr[exp_n] = a; exp_wr[exp_n] = 1'b1; exp_n++;
        end
        4'd1: begin
          exp_rbuf[8*(r*3+2) +: 8] = exp_regs[a[7:0]];
          exp_addr[exp_n] = a; exp_wr[exp_n] = 1'b0; exp_n++;
        end
        default: begin
          mk = b[8*(r*4+3) +: 8];
          ov = exp_regs[a[7:0]];
          exp_regs[a[7:0]] = (ov & ~mk) | (nv & mk);
          exp_addr[exp_n] = a; exp_wr[exp_n] = 1'b0; exp_n++;
          exp_addr[exp_n] = a; exp_wr[exp_n] = 1'b1; exp_n++;
        end
      endcase
    end
  endtask

  task automatic compare_all(input string req, input logic [7:0] ecode, input int elat, input int lstart);
    int bad;
    check(got_lat == elat, req, "cycles to done", 128'(got_lat), 128'(elat));
    check(got_code == ecode, req, "error code", 128'(got_code), 128'(ecode));
    check(got_err == (ecode != 8'h00), req, "err flag", 128'(got_err), 128'(ecode != 8'h00));
    check(got_rbuf == exp_rbuf, req, "result buffer", got_rbuf, exp_rbuf);
    bad = 0;
    for (int i = 0; i < 256; i++) if (regs[i] !== exp_regs[i]) bad++;
    check(bad == 0, req, "register image mismatches", 128'(bad), 128'(0));
    bad = (log_n - lstart == exp_n) ? 0 : 1;
    for (int i = 0; i < exp_n && bad == 0; i++)
      if (log_addr[lstart+i] !== exp_addr[i] || log_wr[lstart+i] !== exp_wr[i]) bad = 1;
    check(bad == 0, "R5", {req, " access sequence"}, 128'(log_n - lstart), 128'(exp_n));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lstart;
    logic [127:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    check(!busy && !done && !err, "R8", "reset flags", {busy, done, err}, 0);
    check(err_code == 8'h00 && rbuf == '0, "R8", "reset code/rbuf", rbuf, 0);
    check(!reg_rd_en && !reg_wr_en, "R5", "reset strobes", {reg_rd_en, reg_wr_en}, 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      b = make_buf(VECS[v].seed);
      for (int i = 0; i < 256; i++) exp_regs[i] = regs[i];
      model(VECS[v].sub, VECS[v].size, b, VECS[v].code);
      lstart = log_n;
      run_cmd(VECS[v].sub, VECS[v].size, b);
      compare_all($sformatf("vec%0d R2/R3/R4/R6/R7/R9", v), VECS[v].code, int'(VECS[v].lat), lstart);
    end

    // R8 error code held after done, err low outside done
    run_cmd(4'd0, 8'd5, make_buf(8'd20));
    repeat (3) @(negedge clk);
    check(err_code == 8'h02 && !err && !done, "R8", "held code", 128'(err_code), 128'(2));

    // R1 foreign message code ignored
    lstart = log_n;
    @(negedge clk);
    start = 1'b1; msg_code = 8'hFE; sub_id = 4'd0; size = 8'd3; wbuf = make_buf(8'd21);
    @(negedge clk);
    start = 1'b0;
    begin
      int seen = 0;
      for (int c = 0; c < 8; c++) begin
        if (done || busy) seen++;
        @(negedge clk);
      end
      check(seen == 0, "R1", "foreign code busy/done cycles", 128'(seen), 0);
    end
    check(log_n == lstart, "R1", "foreign code accesses", 128'(log_n - lstart), 0);
    check(err_code == 8'h02, "R1", "code untouched", 128'(err_code), 128'(2));

    // R1 start while busy ignored: write 2 records, hold start with another command
    b = make_buf(8'd22);
    for (int i = 0; i < 256; i++) exp_regs[i] = regs[i];
    model(4'd0, 8'd6, b, 8'h00);
    lstart = log_n;
    start = 1'b1; msg_code = 8'hFF; sub_id = 4'd0; size = 8'd6; wbuf = b;
    @(posedge clk);
    @(negedge clk);
    sub_id = 4'd1; size = 8'd3; wbuf = make_buf(8'd23);
    got_lat = 1;
    while (!done && got_lat < 40) begin
      @(negedge clk);
      got_lat++;
      if (got_lat == 2) start = 1'b0;
    end
    start = 1'b0;
    got_code = err_code; got_err = err; got_rbuf = rbuf;
    @(negedge clk);
    check(!busy && !done, "R1", "idle after busy start", {busy, done}, 0);
    compare_all("R1 busy start", 8'h00, 3, lstart);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule